// File: doc/BRIEF.md
# Guest Debug State Keeper with Pending Single-Step Tracking

This block holds the virtualized debug state of one guest across transitions between guest execution and hypervisor control. It keeps two sets of images: the live set the guest runs with, and a saved set the hypervisor owns. Each set has a breakpoint-control register image, a debug-control MSR image that carries a branch-trap flag, and a pending-debug-exceptions field with a single-step pending bit.

On an exit strobe, the live control register and MSR images are copied into the saved set. In that same cycle, any guest-side update to the live images is dropped, so the saved copy shows the state from before the debug event. On an entry strobe, all three live images are reloaded from the saved set. One cycle later, the block reports whether a pending debug exception must be delivered.

While the guest is out, the hypervisor may emulate a guest write to the debug-control MSR. The block applies that write to the saved MSR image. When the guest's trap flag is set and debug exceptions are blocked, the same write also forces the single-step pending bit. The bit is set when the new branch-trap flag is 0 and cleared when it is 1.

Top module: `dbg_pending_tracker`

## Requirements
- R1: One cycle after `exit_stb`, the saved control image equals the live control image and the saved MSR image equals the live MSR image, both as they were in the strobe cycle.
- R2: One cycle after `entry_stb`, all three live images (control, MSR, pending) equal the saved images as they were in the strobe cycle.
- R3: `pend_valid` is high for exactly the one cycle after an `entry_stb` cycle in which saved pending bit 14 (single-step) was 1. It is low otherwise. The MSR branch-trap flag (bit 1) and the trap-flag input play no part in it.
- R4: Consider an emulated MSR write with `trap_flag`=1 and `dbg_blocked`=1 and no exit in the same cycle. If the written bit 1 is 0, saved pending bit 14 is 1 afterwards.
- R5: Under the same condition, if the written bit 1 is 1, saved pending bit 14 is 0 afterwards.
- R6: An emulated MSR write made without both `trap_flag` and `dbg_blocked` high leaves the saved pending field unchanged. In every case with no exit, the saved MSR image takes the written value.
- R7: In a cycle with `exit_stb` and no `entry_stb`, guest updates to the live images are dropped. The live images keep their values, and the saved set captures the values from before the update.
- R8: If `exit_stb` and `emu_we` arrive in the same cycle, the exit capture wins. The emulated write changes neither the saved MSR image nor the saved pending field.
- R9: While `rst` is high, all images of both sets are cleared to zero on the clock edge, and `pend_valid` is 0.
- R10: With no strobe, a guest update (`gst_ctl_we` / `gst_msr_we`) loads the live control / MSR image on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exit_stb | input | 1 | Guest-to-hypervisor transition; capture live into saved |
| entry_stb | input | 1 | Hypervisor-to-guest transition; reload live from saved |
| gst_ctl_we | input | 1 | Guest-side update of the live control image |
| gst_ctl_wd | input | 32 | New live control image value |
| gst_msr_we | input | 1 | Guest-side update of the live MSR image |
| gst_msr_wd | input | 16 | New live MSR image value |
| emu_we | input | 1 | Hypervisor-emulated write to the saved MSR image |
| emu_wd | input | 16 | Emulated MSR write value (bit 1 = branch-trap flag) |
| trap_flag | input | 1 | Guest single-step trap flag at the emulated write |
| dbg_blocked | input | 1 | Debug exceptions blocked at the emulated write |
| live_ctl | output | 32 | Live control image |
| live_msr | output | 16 | Live MSR image |
| live_pend | output | 16 | Live pending-debug-exceptions field |
| sav_ctl | output | 32 | Saved control image |
| sav_msr | output | 16 | Saved MSR image |
| sav_pend | output | 16 | Saved pending field (bit 14 = single-step) |
| pend_valid | output | 1 | One-cycle pulse: pending debug exception to deliver after entry |

## Verification
An exit capture can land in the same cycle as either an emulated MSR write or a guest-side update of the live images. The bench drives each pair in a single cycle, including an emulated write that would otherwise have cleared the single-step bit. It then checks the next cycle: the saved MSR must match the live MSR from before that cycle, the pending field must be unchanged, and the live images must not move. A reference model built from the requirements predicts every output for every cycle.

// File: rtl/dbgtrk_pkg.sv
package dbgtrk_pkg;

    parameter int CTL_W     = 32;
    parameter int MSR_W     = 16;
    parameter int PEND_W    = 16;
    parameter int BRT_POS   = 1;   // branch-trap flag in the MSR image
    parameter int SSTEP_POS = 14;  // single-step pending bit

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [MSR_W-1:0]  msr;
        logic [PEND_W-1:0] pend;
    } dbg_img_t;

    typedef enum logic [1:0] {
        SS_KEEP = 2'd0,
        SS_SET  = 2'd1,
        SS_CLR  = 2'd2
    } ss_act_e;

    // Effect of an emulated MSR write on the single-step pending bit
    function automatic ss_act_e ss_action(input logic tf, input logic blk,
                                          input logic brt_new);
        if (!(tf && blk))
            return SS_KEEP;
        return brt_new ? SS_CLR : SS_SET;
    endfunction

endpackage

// File: rtl/dbgtrk_live.sv
module dbgtrk_live
    import dbgtrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exit_stb,
    input  logic             entry_stb,
    input  logic             gst_ctl_we,
    input  logic [CTL_W-1:0] gst_ctl_wd,
    input  logic             gst_msr_we,
    input  logic [MSR_W-1:0] gst_msr_wd,
    input  dbg_img_t         saved,
    output dbg_img_t         live
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (entry_stb) begin
            live <= saved;
        end else if (!exit_stb) begin
            if (gst_ctl_we) live.ctl <= gst_ctl_wd;
            if (gst_msr_we) live.msr <= gst_msr_wd;
        end
    end

    p_entry_reload_r2: assert property (@(posedge clk) disable iff (rst)
        entry_stb |=> live == $past(saved));

    p_exit_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        exit_stb && !entry_stb |=> $stable(live));

endmodule

// File: rtl/dbgtrk_save.sv
module dbgtrk_save
    import dbgtrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exit_stb,
    input  logic [CTL_W-1:0] live_ctl,
    input  logic [MSR_W-1:0] live_msr,
    input  logic             emu_we,
    input  logic [MSR_W-1:0] emu_wd,
    input  logic             trap_flag,
    input  logic             dbg_blocked,
    output dbg_img_t         saved
);

    ss_act_e act;
    assign act = ss_action(trap_flag, dbg_blocked, emu_wd[BRT_POS]);

    always_ff @(posedge clk) begin
        if (rst) begin
            saved <= '0;
        end else if (exit_stb) begin
            saved.ctl <= live_ctl;
            saved.msr <= live_msr;
        end else if (emu_we) begin
            saved.msr <= emu_wd;
            case (act)
                SS_SET:  saved.pend[SSTEP_POS] <= 1'b1;
                SS_CLR:  saved.pend[SSTEP_POS] <= 1'b0;
                default: ;
            endcase
        end
    end

    p_exit_capture_r1: assert property (@(posedge clk) disable iff (rst)
        exit_stb |=> saved.ctl == $past(live_ctl) && saved.msr == $past(live_msr));

    p_ss_set_r4: assert property (@(posedge clk) disable iff (rst)
        emu_we && !exit_stb && trap_flag && dbg_blocked && !emu_wd[BRT_POS]
        |=> saved.pend[SSTEP_POS]);

    p_ss_clr_r5: assert property (@(posedge clk) disable iff (rst)
        emu_we && !exit_stb && trap_flag && dbg_blocked && emu_wd[BRT_POS]
        |=> !saved.pend[SSTEP_POS]);

    p_ss_hold_r6: assert property (@(posedge clk) disable iff (rst)
        emu_we && !exit_stb && !(trap_flag && dbg_blocked)
        |=> $stable(saved.pend) && saved.msr == $past(emu_wd));

    p_exit_wins_r8: assert property (@(posedge clk) disable iff (rst)
        exit_stb && emu_we |=> saved.msr == $past(live_msr) && $stable(saved.pend));

endmodule

// File: rtl/dbgtrk_pendflag.sv
module dbgtrk_pendflag (
    input  logic clk,
    input  logic rst,
    input  logic entry_stb,
    input  logic saved_ss,
    output logic pend_valid
);

    always_ff @(posedge clk) begin
        if (rst) pend_valid <= 1'b0;
        else     pend_valid <= entry_stb && saved_ss;
    end

    p_valid_after_entry_r3: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> $past(entry_stb));

    p_valid_drops_r3: assert property (@(posedge clk) disable iff (rst)
        !entry_stb |=> !pend_valid);

endmodule

// File: rtl/dbg_pending_tracker.sv
module dbg_pending_tracker
    import dbgtrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exit_stb,
    input  logic              entry_stb,
    input  logic              gst_ctl_we,
    input  logic [CTL_W-1:0]  gst_ctl_wd,
    input  logic              gst_msr_we,
    input  logic [MSR_W-1:0]  gst_msr_wd,
    input  logic              emu_we,
    input  logic [MSR_W-1:0]  emu_wd,
    input  logic              trap_flag,
    input  logic              dbg_blocked,
    output logic [CTL_W-1:0]  live_ctl,
    output logic [MSR_W-1:0]  live_msr,
    output logic [PEND_W-1:0] live_pend,
    output logic [CTL_W-1:0]  sav_ctl,
    output logic [MSR_W-1:0]  sav_msr,
    output logic [PEND_W-1:0] sav_pend,
    output logic              pend_valid
);

    dbg_img_t live;
    dbg_img_t saved;

    dbgtrk_live u_live (
        .clk        (clk),
        .rst        (rst),
        .exit_stb   (exit_stb),
        .entry_stb  (entry_stb),
        .gst_ctl_we (gst_ctl_we),
        .gst_ctl_wd (gst_ctl_wd),
        .gst_msr_we (gst_msr_we),
        .gst_msr_wd (gst_msr_wd),
        .saved      (saved),
        .live       (live)
    );

    dbgtrk_save u_save (
        .clk         (clk),
        .rst         (rst),
        .exit_stb    (exit_stb),
        .live_ctl    (live.ctl),
        .live_msr    (live.msr),
        .emu_we      (emu_we),
        .emu_wd      (emu_wd),
        .trap_flag   (trap_flag),
        .dbg_blocked (dbg_blocked),
        .saved       (saved)
    );

    dbgtrk_pendflag u_pend (
        .clk        (clk),
        .rst        (rst),
        .entry_stb  (entry_stb),
        .saved_ss   (saved.pend[SSTEP_POS]),
        .pend_valid (pend_valid)
    );

    assign live_ctl  = live.ctl;
    assign live_msr  = live.msr;
    assign live_pend = live.pend;
    assign sav_ctl   = saved.ctl;
    assign sav_msr   = saved.msr;
    assign sav_pend  = saved.pend;

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> live == '0 && saved == '0 && !pend_valid);

endmodule

// File: tb/sim_dbg_pending_tracker.sv
module sim_dbg_pending_tracker;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, exit_stb, entry_stb, gst_ctl_we, gst_msr_we;
    logic        emu_we, trap_flag, dbg_blocked;
    logic [31:0] gst_ctl_wd;
    logic [15:0] gst_msr_wd, emu_wd;
    logic [31:0] live_ctl, sav_ctl;
    logic [15:0] live_msr, live_pend, sav_msr, sav_pend;
    logic        pend_valid;

    dbg_pending_tracker u0 (
        .clk(clk), .rst(rst), .exit_stb(exit_stb), .entry_stb(entry_stb),
        .gst_ctl_we(gst_ctl_we), .gst_ctl_wd(gst_ctl_wd),
        .gst_msr_we(gst_msr_we), .gst_msr_wd(gst_msr_wd),
        .emu_we(emu_we), .emu_wd(emu_wd), .trap_flag(trap_flag),
        .dbg_blocked(dbg_blocked),
        .live_ctl(live_ctl), .live_msr(live_msr), .live_pend(live_pend),
        .sav_ctl(sav_ctl), .sav_msr(sav_msr), .sav_pend(sav_pend),
        .pend_valid(pend_valid)
    );

    typedef struct {
        string       tag;
        logic [31:0] lc;
        logic [15:0] lm;
        logic [15:0] lp;
        logic [31:0] sc;
        logic [15:0] sm;
        logic [15:0] sp;
        logic        v;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // reference model state
    logic [31:0] m_lc, m_sc;
    logic [15:0] m_lm, m_lp, m_sm, m_sp;

    task automatic idle_inputs();
        exit_stb = 0; entry_stb = 0; gst_ctl_we = 0; gst_msr_we = 0;
        emu_we = 0; trap_flag = 0; dbg_blocked = 0;
        gst_ctl_wd = '0; gst_msr_wd = '0; emu_wd = '0;
    endtask

    // driver: predicts the next-cycle outputs, queues them, advances a cycle
    task automatic tick(input string tag);
        exp_t e;
        logic [31:0] nlc, nsc;
        logic [15:0] nlm, nlp, nsm, nsp;
        logic        nv;
        if (rst) begin
            nlc = '0; nlm = '0; nlp = '0; nsc = '0; nsm = '0; nsp = '0; nv = 0;
        end else begin
            nv  = entry_stb && m_sp[14];
            nlc = m_lc; nlm = m_lm; nlp = m_lp;
            if (entry_stb) begin
                nlc = m_sc; nlm = m_sm; nlp = m_sp;
            end else if (!exit_stb) begin
                if (gst_ctl_we) nlc = gst_ctl_wd;
                if (gst_msr_we) nlm = gst_msr_wd;
            end
            nsc = m_sc; nsm = m_sm; nsp = m_sp;
            if (exit_stb) begin
                nsc = m_lc; nsm = m_lm;
            end else if (emu_we) begin
                nsm = emu_wd;
                if (trap_flag && dbg_blocked) nsp[14] = ~emu_wd[1];
            end
        end
        m_lc = nlc; m_lm = nlm; m_lp = nlp; m_sc = nsc; m_sm = nsm; m_sp = nsp;
        e.tag = tag; e.lc = nlc; e.lm = nlm; e.lp = nlp;
        e.sc = nsc; e.sm = nsm; e.sp = nsp; e.v = nv;
        q.push_back(e);
        @(negedge clk);
        idle_inputs();
    endtask

    // monitor: compares one queued item per cycle, after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (live_ctl !== e.lc || live_msr !== e.lm || live_pend !== e.lp ||
                    sav_ctl !== e.sc || sav_msr !== e.sm || sav_pend !== e.sp ||
                    pend_valid !== e.v) begin
                    fails++;
                    $display("FAIL %s actual lc=%h lm=%h lp=%h sc=%h sm=%h sp=%h v=%b expected lc=%h lm=%h lp=%h sc=%h sm=%h sp=%h v=%b",
                             e.tag, live_ctl, live_msr, live_pend, sav_ctl, sav_msr,
                             sav_pend, pend_valid, e.lc, e.lm, e.lp, e.sc, e.sm,
                             e.sp, e.v);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: all requirements, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1;
        idle_inputs();
        m_lc = '0; m_lm = '0; m_lp = '0; m_sc = '0; m_sm = '0; m_sp = '0;
        @(negedge clk);
        // R9: reset clears everything, even with stimulus present
        gst_ctl_we = 1; gst_ctl_wd = 32'hDEAD_BEEF; emu_we = 1; emu_wd = 16'h0000;
        trap_flag = 1; dbg_blocked = 1;
        tick("R9");
        tick("R9");
        rst = 0;

        // R10: guest updates the live images
        gst_ctl_we = 1; gst_ctl_wd = 32'hA5A5_0081;
        gst_msr_we = 1; gst_msr_wd = 16'h0002;
        tick("R10");

        // R1: exit captures control and MSR images
        exit_stb = 1;
        tick("R1");

        gst_ctl_we = 1; gst_ctl_wd = 32'h0000_0400;
        tick("R10");

        // R7: guest update in the exit cycle is dropped
        exit_stb = 1;
        gst_ctl_we = 1; gst_ctl_wd = 32'hFFFF_FFFF;
        gst_msr_we = 1; gst_msr_wd = 16'h00FF;
        tick("R7");

        // R4: branch-trap cleared under trap flag + blocking sets single-step
        emu_we = 1; emu_wd = 16'h0000; trap_flag = 1; dbg_blocked = 1;
        tick("R4");

        // R2 and R3: entry reloads all images and raises valid for one cycle
        entry_stb = 1;
        tick("R2");
        tick("R3");

        // R6: writes outside the condition leave the pending bit alone
        emu_we = 1; emu_wd = 16'h0002; trap_flag = 1; dbg_blocked = 0;
        tick("R6");
        emu_we = 1; emu_wd = 16'h0000; trap_flag = 0; dbg_blocked = 1;
        tick("R6");

        // R5: branch-trap set under the condition clears single-step
        emu_we = 1; emu_wd = 16'h0002; trap_flag = 1; dbg_blocked = 1;
        tick("R5");

        // R3: entry with single-step clear gives no valid
        entry_stb = 1;
        tick("R3");

        // R3: valid regardless of branch-trap flag and trap flag
        emu_we = 1; emu_wd = 16'h0000; trap_flag = 1; dbg_blocked = 1;
        tick("R4");
        emu_we = 1; emu_wd = 16'h0002; trap_flag = 0; dbg_blocked = 0;
        tick("R6");
        entry_stb = 1;
        tick("R3");
        tick("R3");

        // R8: exit and emulated write together, exit wins
        gst_msr_we = 1; gst_msr_wd = 16'h0081;
        tick("R10");
        exit_stb = 1;
        emu_we = 1; emu_wd = 16'h0002; trap_flag = 1; dbg_blocked = 1;
        tick("R8");
        tick("R8");

        // R2: second entry reloads the captured state
        entry_stb = 1;
        tick("R2");
        tick("R3");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule